// File: doc/BRIEF.md
# Variable-Size Register Window Stack

This block is a register file organised as a stack of procedure windows, where each call picks the size of its own window. A call carries two immediates: the size of the new window and the number of the caller's top registers that are shared with the callee as parameters. The callee's window starts where the caller's unshared part ends. Its low registers are therefore the caller's outgoing-parameter registers, and it extends upward by the requested size. A return releases the window and puts back the caller's base and size. These come from a small hardware stack of frame records, so the return needs no operand.

Logical register numbers below the global count always reach the same physical entries. Higher logical numbers are offsets into the current window. They go through a base-plus-offset adder on each of the two read ports and on the write port. Bounds are tested once when a call is made and once when a return is made. A call that does not fit raises an overflow trap. A return with nothing to pop raises an underflow trap. An ordinary access outside the current window only reads zero, has its write dropped and raises a per-port range flag. Spilling, trap handling and instruction decode belong to the surrounding core.

Top module: `rwin_stack`

## Requirements
- R1: After reset the window base is 16 and the window size is 16. Both traps are low and the frame stack is empty, so a first return raises the underflow trap.
- R2: Logical registers 0 to 15 are globals. They reach physical entries 0 to 15 whatever the current window is.
- R3: A logical register L of 16 or more with offset L-16 below the window size reaches physical entry base+(L-16). Reads are combinational from the register number.
- R4: A call with size S (6 bits, `call_size`) and shared count P (6 bits, `call_params`) is accepted when all of the following hold: P is no larger than the current size, the stack holds fewer than 16 records, and base+size-P+S is at most 128. From the next cycle the base is base+size-P and the size is S. Callee offsets 0 to P-1 are the same entries as caller offsets size-P to size-1.
- R5: A call that is not accepted leaves the base, size and stack unchanged. `ovf_trap` is high for exactly the one cycle after it.
- R6: A return with a non-empty stack restores the caller's base and size in the next cycle. A return with an empty stack changes nothing, and `unf_trap` is high for exactly the one cycle after it.
- R7: A windowed register whose offset is at or beyond the window size reads as 0 and raises that read port's range flag. A write to it raises `wr_range_err` and leaves every entry unchanged.
- R8: A write in the same cycle as a call or return is mapped with the base and size in force before that call or return.
- R9: When call and return are requested in the same cycle, only the call acts. The return is ignored and raises no underflow.
- R10: A 17th nested call, made while 16 frames are stacked, is refused with an overflow trap even when the window would fit.
- R11: A write becomes visible on the read ports in the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_valid | input | 1 | Call request this cycle |
| call_size | input | 6 | Size of the callee window |
| call_params | input | 6 | Caller registers shared with the callee |
| ret_valid | input | 1 | Return request this cycle |
| wr_en | input | 1 | Write request |
| wr_lreg | input | 6 | Logical register to write |
| wr_data | input | 32 | Write data |
| wr_range_err | output | 1 | Write target lies outside the window |
| rd0_lreg | input | 6 | Logical register for read port 0 |
| rd0_data | output | 32 | Read port 0 data |
| rd0_range_err | output | 1 | Read port 0 target outside the window |
| rd1_lreg | input | 6 | Logical register for read port 1 |
| rd1_data | output | 32 | Read port 1 data |
| rd1_range_err | output | 1 | Read port 1 target outside the window |
| ovf_trap | output | 1 | One-cycle pulse after a refused call |
| unf_trap | output | 1 | One-cycle pulse after a refused return |
| window_base | output | 8 | Physical base of the current window |
| window_size | output | 6 | Size of the current window |

## Verification
Read data and the three range flags depend only on the current inputs and state. They are checked in the same cycle the register numbers are applied. The window base, the size and both trap pulses change at the clock edge that takes the call or return, so they are checked one cycle after the request. A written value is expected on the read ports from the cycle after the write edge. The behavioural model applies the write before the frame change at the same edge. Every comparison is made at the falling clock edge, after the inputs that were changed just past the rising edge have settled.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

  localparam int RW_SIZE_W = 6;

  typedef logic [RW_SIZE_W-1:0] wsize_t;

  // one saved frame: how far the base moved, and the caller's size
  typedef struct packed {
    wsize_t adv;
    wsize_t size;
  } frame_rec_t;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_CALL = 2'd1,
    OP_RET  = 2'd2
  } frame_op_e;

endpackage

// File: rtl/rwin_map.sv
module rwin_map
  import rwin_pkg::*;
#(
  parameter int PHYS_REGS   = 128,
  parameter int NUM_GLOBALS = 16,
  parameter int LREG_W      = 6
) (
  input  logic [LREG_W-1:0]                  lreg,
  input  logic [$clog2(PHYS_REGS+1)-1:0]     base,
  input  wsize_t                             size,
  output logic [$clog2(PHYS_REGS)-1:0]       phys,
  output logic                               hit
);

  localparam int PA_W   = $clog2(PHYS_REGS);
  localparam int BASE_W = $clog2(PHYS_REGS + 1);
  localparam int SUM_W  = BASE_W + 1;

  logic             is_glob;
  logic [SUM_W-1:0] off_x;
  logic [SUM_W-1:0] sum_x;
  logic             in_win;
  logic             in_phys;

  always_comb begin
    is_glob = (SUM_W'(lreg) < SUM_W'(NUM_GLOBALS));
    off_x   = SUM_W'(lreg) - SUM_W'(NUM_GLOBALS);
    in_win  = (off_x < SUM_W'(size));
    // explicit base-plus-offset adder in the address path
    sum_x   = SUM_W'(base) + off_x;
    in_phys = (sum_x < SUM_W'(PHYS_REGS));
    hit     = is_glob | (in_win & in_phys);
    phys    = is_glob ? PA_W'(lreg) : sum_x[PA_W-1:0];
  end

endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile #(
  parameter int PHYS_REGS = 128,
  parameter int DATA_W    = 32
) (
  input  logic                         clk,
  input  logic                         we,
  input  logic [$clog2(PHYS_REGS)-1:0] waddr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [$clog2(PHYS_REGS)-1:0] raddr0,
  output logic [DATA_W-1:0]            rdata0,
  input  logic [$clog2(PHYS_REGS)-1:0] raddr1,
  output logic [DATA_W-1:0]            rdata1
);

  logic [DATA_W-1:0] mem_q [PHYS_REGS];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata0 = mem_q[raddr0];
    rdata1 = mem_q[raddr1];
  end

endmodule

// File: rtl/rwin_frame_ctl.sv
module rwin_frame_ctl
  import rwin_pkg::*;
#(
  parameter int PHYS_REGS   = 128,
  parameter int NUM_GLOBALS = 16,
  parameter int STACK_DEPTH = 16,
  parameter int RESET_SIZE  = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           call_valid,
  input  wsize_t                         call_size,
  input  wsize_t                         call_params,
  input  logic                           ret_valid,
  output logic [$clog2(PHYS_REGS+1)-1:0] base_o,
  output wsize_t                         size_o,
  output logic                           ovf_o,
  output logic                           unf_o
);

  localparam int BASE_W = $clog2(PHYS_REGS + 1);
  localparam int SUM_W  = BASE_W + 1;
  localparam int DEP_W  = $clog2(STACK_DEPTH + 1);
  localparam int IDX_W  = $clog2(STACK_DEPTH);

  logic [BASE_W-1:0] base_q, base_d;
  wsize_t            size_q, size_d;
  logic [DEP_W-1:0]  depth_q, depth_d;
  logic              ovf_q, ovf_d;
  logic              unf_q, unf_d;
  frame_rec_t        stk_q [STACK_DEPTH];

  frame_op_e         op;
  wsize_t            adv;
  logic [SUM_W-1:0]  new_base;
  logic [SUM_W-1:0]  new_lim;
  logic              full, empty;
  logic              call_ok, ret_ok;
  logic [IDX_W-1:0]  push_idx, top_idx;
  frame_rec_t        top_rec;
  frame_rec_t        push_rec;

  always_comb begin
    // a call takes priority over a simultaneous return
    if (call_valid)     op = OP_CALL;
    else if (ret_valid) op = OP_RET;
    else                op = OP_NONE;

    full     = (depth_q == DEP_W'(STACK_DEPTH));
    empty    = (depth_q == '0);
    push_idx = IDX_W'(depth_q);
    top_idx  = IDX_W'(depth_q - DEP_W'(1));
    top_rec  = stk_q[top_idx];

    adv      = size_q - call_params;
    new_base = SUM_W'(base_q) + SUM_W'(adv);
    new_lim  = new_base + SUM_W'(call_size);

    // the single bounds test made at call time
    call_ok  = (op == OP_CALL) && (call_params <= size_q) && !full &&
               (new_lim <= SUM_W'(PHYS_REGS));
    // the single bounds test made at return time
    ret_ok   = (op == OP_RET) && !empty;

    push_rec.adv  = adv;
    push_rec.size = size_q;
  end

  always_comb begin
    base_d  = base_q;
    size_d  = size_q;
    depth_d = depth_q;
    ovf_d   = (op == OP_CALL) && !call_ok;
    unf_d   = (op == OP_RET)  && !ret_ok;
    if (call_ok) begin
      base_d  = BASE_W'(new_base);
      size_d  = call_size;
      depth_d = depth_q + DEP_W'(1);
    end else if (ret_ok) begin
      base_d  = base_q - BASE_W'(top_rec.adv);
      size_d  = top_rec.size;
      depth_d = depth_q - DEP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= BASE_W'(NUM_GLOBALS);
      size_q  <= wsize_t'(RESET_SIZE);
      depth_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      base_q  <= base_d;
      size_q  <= size_d;
      depth_q <= depth_d;
      ovf_q   <= ovf_d;
      unf_q   <= unf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (call_ok) begin
      stk_q[push_idx] <= push_rec;
    end
  end

  assign base_o = base_q;
  assign size_o = size_q;
  assign ovf_o  = ovf_q;
  assign unf_o  = unf_q;

  // R4: the current window always lies inside the physical file
  assert_window_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (SUM_W'(base_q) + SUM_W'(size_q)) <= SUM_W'(PHYS_REGS));

  // R5: a refused call left the frame untouched
  assert_ovf_keeps_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> ($stable(base_q) && $stable(size_q) && $stable(depth_q)));

  // R6: a refused return left the frame untouched
  assert_unf_keeps_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    unf_q |-> ($stable(base_q) && $stable(size_q) && $stable(depth_q)));

  // R9: both traps never pulse together
  assert_traps_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_q && unf_q));

  // R10: stack depth never exceeds its capacity
  assert_depth_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= DEP_W'(STACK_DEPTH));

endmodule

// File: rtl/rwin_stack.sv
module rwin_stack
  import rwin_pkg::*;
#(
  parameter int PHYS_REGS   = 128,
  parameter int NUM_GLOBALS = 16,
  parameter int STACK_DEPTH = 16,
  parameter int RESET_SIZE  = 16,
  parameter int DATA_W      = 32,
  parameter int LREG_W      = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           call_valid,
  input  logic [RW_SIZE_W-1:0]           call_size,
  input  logic [RW_SIZE_W-1:0]           call_params,
  input  logic                           ret_valid,
  input  logic                           wr_en,
  input  logic [LREG_W-1:0]              wr_lreg,
  input  logic [DATA_W-1:0]              wr_data,
  output logic                           wr_range_err,
  input  logic [LREG_W-1:0]              rd0_lreg,
  output logic [DATA_W-1:0]              rd0_data,
  output logic                           rd0_range_err,
  input  logic [LREG_W-1:0]              rd1_lreg,
  output logic [DATA_W-1:0]              rd1_data,
  output logic                           rd1_range_err,
  output logic                           ovf_trap,
  output logic                           unf_trap,
  output logic [$clog2(PHYS_REGS+1)-1:0] window_base,
  output logic [RW_SIZE_W-1:0]           window_size
);

  localparam int PA_W    = $clog2(PHYS_REGS);
  localparam int BASE_W  = $clog2(PHYS_REGS + 1);
  localparam int N_PORTS = 3;   // index 0: write, 1: read 0, 2: read 1

  logic [BASE_W-1:0] base;
  wsize_t            size;
  logic [LREG_W-1:0] lreg_a [N_PORTS];
  logic [PA_W-1:0]   phys_a [N_PORTS];
  logic              hit_a  [N_PORTS];
  logic [DATA_W-1:0] raw0, raw1;
  logic              wr_go;

  rwin_frame_ctl #(
    .PHYS_REGS  (PHYS_REGS),
    .NUM_GLOBALS(NUM_GLOBALS),
    .STACK_DEPTH(STACK_DEPTH),
    .RESET_SIZE (RESET_SIZE)
  ) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .call_valid (call_valid),
    .call_size  (call_size),
    .call_params(call_params),
    .ret_valid  (ret_valid),
    .base_o     (base),
    .size_o     (size),
    .ovf_o      (ovf_trap),
    .unf_o      (unf_trap)
  );

  assign lreg_a[0] = wr_lreg;
  assign lreg_a[1] = rd0_lreg;
  assign lreg_a[2] = rd1_lreg;

  for (genvar g = 0; g < N_PORTS; g++) begin : g_map
    rwin_map #(
      .PHYS_REGS  (PHYS_REGS),
      .NUM_GLOBALS(NUM_GLOBALS),
      .LREG_W     (LREG_W)
    ) u_map (
      .lreg(lreg_a[g]),
      .base(base),
      .size(size),
      .phys(phys_a[g]),
      .hit (hit_a[g])
    );
  end

  // the write uses the mapping registered before any frame change this cycle
  assign wr_go = wr_en & hit_a[0];

  rwin_regfile #(
    .PHYS_REGS(PHYS_REGS),
    .DATA_W   (DATA_W)
  ) u_rf (
    .clk   (clk),
    .we    (wr_go),
    .waddr (phys_a[0]),
    .wdata (wr_data),
    .raddr0(phys_a[1]),
    .rdata0(raw0),
    .raddr1(phys_a[2]),
    .rdata1(raw1)
  );

  always_comb begin
    rd0_data      = hit_a[1] ? raw0 : '0;
    rd1_data      = hit_a[2] ? raw1 : '0;
    rd0_range_err = ~hit_a[1];
    rd1_range_err = ~hit_a[2];
    wr_range_err  = wr_en & ~hit_a[0];
  end

  assign window_base = base;
  assign window_size = size;

  // R2: a global register number is never reported out of range
  assert_global_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rd0_lreg) < NUM_GLOBALS) |-> !rd0_range_err);

endmodule

// File: tb/tb_rwin_stack.sv
module tb_rwin_stack;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        call_valid, ret_valid, wr_en;
  logic [5:0]  call_size, call_params, wr_lreg, rd0_lreg, rd1_lreg;
  logic [31:0] wr_data, rd0_data, rd1_data;
  logic        wr_range_err, rd0_range_err, rd1_range_err, ovf_trap, unf_trap;
  logic [7:0]  window_base;
  logic [5:0]  window_size;

  always #5 clk = ~clk;

  rwin_stack dut (
    .clk(clk), .rst_n(rst_n), .call_valid(call_valid), .call_size(call_size),
    .call_params(call_params), .ret_valid(ret_valid), .wr_en(wr_en),
    .wr_lreg(wr_lreg), .wr_data(wr_data), .wr_range_err(wr_range_err),
    .rd0_lreg(rd0_lreg), .rd0_data(rd0_data), .rd0_range_err(rd0_range_err),
    .rd1_lreg(rd1_lreg), .rd1_data(rd1_data), .rd1_range_err(rd1_range_err),
    .ovf_trap(ovf_trap), .unf_trap(unf_trap), .window_base(window_base),
    .window_size(window_size)
  );

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          mbase, msize, mdepth;
  int          madv [16];
  int          msz  [16];
  logic [31:0] mmem [128];
  bit          mknown [128];
  bit          movf, munf;

  function automatic void mmap(input int l, output bit ok, output int p);
    if (l < 16) begin
      ok = 1'b1; p = l;
    end else begin
      ok = (l - 16) < msize; p = mbase + l - 16;
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit ok;
    int p;
    if (!rst_n) begin
      mbase = 16; msize = 16; mdepth = 0; movf = 0; munf = 0;
    end else begin
      if (wr_en) begin
        mmap(int'(wr_lreg), ok, p);
        if (ok) begin mmem[p] = wr_data; mknown[p] = 1'b1; end
      end
      movf = 0; munf = 0;
      if (call_valid) begin
        if (int'(call_params) > msize || mdepth == 16 ||
            mbase + msize - int'(call_params) + int'(call_size) > 128) begin
          movf = 1;
        end else begin
          madv[mdepth] = msize - int'(call_params);
          msz[mdepth]  = msize;
          mdepth++;
          mbase = mbase + msize - int'(call_params);
          msize = int'(call_size);
        end
      end else if (ret_valid) begin
        if (mdepth == 0) munf = 1;
        else begin
          mdepth--;
          mbase = mbase - madv[mdepth];
          msize = msz[mdepth];
        end
      end
    end
  end

  task automatic rd_cmp(input logic [5:0] l, input logic [31:0] d, input logic e, input string port);
    bit ok;
    int p;
    string tag;
    mmap(int'(l), ok, p);
    tag = (l < 16) ? {"R2 ", port} : {"R3 ", port};
    chk({"R7 flag ", port}, 64'(e), 64'(!ok));
    if (!ok) chk({"R7 zero ", port}, 64'(d), 64'd0);
    else if (mknown[p]) chk(tag, 64'(d), 64'(mmem[p]));
  endtask

  always @(negedge clk) begin : compare
    bit ok;
    int p;
    if (rst_n && cmp_on) begin
      chk("R4 base", 64'(window_base), 64'(mbase));
      chk("R4 size", 64'(window_size), 64'(msize));
      chk("R5 ovf", 64'(ovf_trap), 64'(movf));
      chk("R6 unf", 64'(unf_trap), 64'(munf));
      rd_cmp(rd0_lreg, rd0_data, rd0_range_err, "rd0");
      rd_cmp(rd1_lreg, rd1_data, rd1_range_err, "rd1");
      mmap(int'(wr_lreg), ok, p);
      chk("R7 wr flag", 64'(wr_range_err), 64'(wr_en && !ok));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle();
    call_valid = 0; ret_valid = 0; wr_en = 0;
    call_size = 0; call_params = 0; wr_lreg = 0; wr_data = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_call(input int p, input int s);
    idle(); call_valid = 1; call_params = 6'(p); call_size = 6'(s);
    tick(); idle();
  endtask

  task automatic do_ret();
    idle(); ret_valid = 1; tick(); idle();
  endtask

  initial begin : watchdog
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    idle(); rd0_lreg = 0; rd1_lreg = 0;
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    cmp_on = 1;
    #1;
    chk("R1 base", 64'(window_base), 64'd16);
    chk("R1 size", 64'(window_size), 64'd16);
    chk("R1 traps", 64'({ovf_trap, unf_trap}), 64'd0);
    do_ret();
    chk("R1 empty stack unf", 64'(unf_trap), 64'd1);
    chk("R1 base kept", 64'(window_base), 64'd16);
    tick();
    chk("R6 unf one cycle", 64'(unf_trap), 64'd0);

    for (int i = 0; i < 32; i++) begin
      wr_en = 1; wr_lreg = 6'(i); wr_data = 32'hA000 + i; tick();
    end
    idle();

    rd0_lreg = 5; rd1_lreg = 20; #1;
    chk("R2 global", 64'(rd0_data), 64'h0000A005);
    chk("R3 window", 64'(rd1_data), 64'h0000A014);

    wr_en = 1; wr_lreg = 9; wr_data = 32'h55; rd0_lreg = 9; #1;
    chk("R11 before edge", 64'(rd0_data), 64'h0000A009);
    tick(); idle(); #1;
    chk("R11 after edge", 64'(rd0_data), 64'h55);

    do_call(0, 16);
    chk("R4 base 32", 64'(window_base), 64'd32);
    wr_en = 1; wr_lreg = 16; wr_data = 32'hBEEF; tick(); idle();
    do_ret();
    chk("R6 restore base", 64'(window_base), 64'd16);
    wr_en = 1; wr_lreg = 32; wr_data = 32'hDEAD; #1;
    chk("R7 wr flag", 64'(wr_range_err), 64'd1);
    tick(); idle();
    rd0_lreg = 32; #1;
    chk("R7 read zero", 64'(rd0_data), 64'd0);
    chk("R7 read flag", 64'(rd0_range_err), 64'd1);
    do_call(0, 16);
    rd0_lreg = 16; #1;
    chk("R7 write ignored", 64'(rd0_data), 64'h0000BEEF);
    do_ret();

    idle(); call_valid = 1; call_params = 4; call_size = 20;
    wr_en = 1; wr_lreg = 17; wr_data = 32'h77;
    tick(); idle();
    chk("R4 call base", 64'(window_base), 64'd28);
    chk("R4 call size", 64'(window_size), 64'd20);
    rd0_lreg = 16; #1;
    chk("R4 alias", 64'(rd0_data), 64'h0000A01C);

    do_call(0, 63);
    chk("R4 base 48", 64'(window_base), 64'd48);
    do_call(0, 30);
    chk("R5 ovf pulse", 64'(ovf_trap), 64'd1);
    chk("R5 base kept", 64'(window_base), 64'd48);
    tick();
    chk("R5 ovf one cycle", 64'(ovf_trap), 64'd0);
    do_ret();
    chk("R6 base 28", 64'(window_base), 64'd28);
    do_call(21, 1);
    chk("R5 params too many", 64'(ovf_trap), 64'd1);
    do_ret();
    chk("R6 base 16", 64'(window_base), 64'd16);
    chk("R6 size 16", 64'(window_size), 64'd16);
    rd0_lreg = 17; #1;
    chk("R8 old mapping", 64'(rd0_data), 64'h77);

    idle(); call_valid = 1; ret_valid = 1; call_params = 0; call_size = 8;
    tick(); idle();
    chk("R9 call wins", 64'(window_base), 64'd32);
    chk("R9 no unf", 64'(unf_trap), 64'd0);
    do_ret();

    do_call(16, 1);
    for (int i = 0; i < 15; i++) do_call(1, 1);
    chk("R10 depth 16 ok", 64'(ovf_trap), 64'd0);
    do_call(1, 1);
    chk("R10 full ovf", 64'(ovf_trap), 64'd1);
    for (int i = 0; i < 16; i++) do_ret();
    chk("R10 unwound size", 64'(window_size), 64'd16);
    do_ret();
    chk("R10 unwound unf", 64'(unf_trap), 64'd1);

    for (int i = 0; i < 3000; i++) begin
      idle();
      call_valid  = ($urandom_range(0, 7) == 0);
      ret_valid   = ($urandom_range(0, 7) == 0);
      call_size   = 6'($urandom_range(0, 40));
      call_params = 6'($urandom_range(0, 20));
      wr_en       = $urandom_range(0, 1) == 1;
      wr_lreg     = 6'($urandom_range(0, 63));
      wr_data     = $urandom;
      rd0_lreg    = 6'($urandom_range(0, 63));
      rd1_lreg    = 6'($urandom_range(0, 63));
      tick();
    end
    idle();
    tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule